// File: doc/BRIEF.md
# DAC Ramp Self-Test Section-Sum Accumulator

This block runs an off-line linearity test of an on-chip DAC. When started, it drives every DAC input code in ascending order and holds each code for a fixed window of 2^M clocks. While a code is held, it counts the ones in the bitstream from a 1-bit sigma-delta modulator that digitizes the DAC output. The first few clocks after each code change are ignored so the analog path can settle. The count of ones left in the window is the measured level for that code.

The measured levels are not stored code by code. They are added into one of four running sums, one for each quarter of the code range. When the ramp ends, the four sums are combined with adds, subtracts and shifts into four third-order fit coefficients: offset, linear, square and cube. Startup firmware starts a run once the digital self-test has finished, and can start it again whenever the system is idle. The modulator enable is high only while a ramp is being measured.

Top module: `dac_ramp_bist`

## Requirements
- R1: While reset is asserted, and after it is released, `busy`, `done` and `mod_en` are 0 and `dac_code` is 0.
- R2: When `start` is high in a clock where `busy` is low, `busy` is 1 from the next clock and `dac_code` is 0.
- R3: During a run, each code is held for exactly 2^OSR_LOG2 clocks. The code then rises by one, from 0 up to 2^CODE_W−1.
- R4: The measured level of a code is the number of ones in `mod_bit` sampled in the window clocks with index SETTLE to 2^OSR_LOG2−1. The first clock of a window has index 0. Samples with an index below SETTLE are ignored.
- R5: The top two bits of the code choose which of four section sums S0..S3 receives the code's level. Code bits 00 select S0 and code bits 11 select S3.
- R6: At the end of a run, `coef_offset` = S0+S1+S2+S3, `coef_linear` = (S2+S3)−(S0+S1), `coef_square` = (S0+S3)−(S1+S2) and `coef_cube` = (S0−S3)−3·(S1−S2). All four are two's complement, COEF_W bits wide.
- R7: `done` is high for exactly one clock, two clocks after the last sample of the ramp. In that same clock `busy` falls. The coefficients are valid while `done` is high and keep their value until the next run finishes.
- R8: A `start` that arrives while `busy` is high is ignored. The ramp sequence and the result are unchanged.
- R9: `mod_en` is high only while ramp samples are being taken. It is low when the block is idle.
- R10: The section sums are cleared at every accepted start, so a run's result depends only on that run's bitstream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a test run |
| mod_bit | input | 1 | Sigma-delta modulator output bit |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-clock pulse when the coefficients are valid |
| mod_en | output | 1 | Modulator enable |
| dac_code | output | CODE_W | Code driven to the DAC under test |
| coef_offset | output | COEF_W | Offset term |
| coef_linear | output | COEF_W | Linear term |
| coef_square | output | COEF_W | Square term |
| coef_cube | output | COEF_W | Cube term |

## Verification
The assertions assume three things about the inputs. `start` may arrive at any time. `mod_bit` is a plain 0/1 level that is sampled on every clock of a run. The modulator delivers its first useful sample in the clock after a code change. The bench drives `mod_bit` and `start` at the falling edge, derived only from its own count of clocks since the accepted start. It uses a small configuration (64 codes, 8-clock window, 2 settling clocks) so that every code of every run is swept. The bitstream patterns include all ones, ones placed only in the settling clocks, and two code-dependent patterns. A second `start` is pulsed in the middle of a run and again in the finishing clock.

// File: rtl/dac_bist_pkg.sv
package dac_bist_pkg;
  localparam int NSEC = 4;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RUN = 2'd1, ST_FIN = 2'd2} bist_state_e;
endpackage

// File: rtl/dac_code_seq.sv
module dac_code_seq #(
  parameter int CODE_W   = 14,
  parameter int OSR_LOG2 = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                step,
  output logic [CODE_W-1:0]   code,
  output logic [OSR_LOG2-1:0] win_idx,
  output logic                win_end,
  output logic                last_code
);
  assign win_end   = &win_idx;
  assign last_code = &code;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      code    <= '0;
      win_idx <= '0;
    end else if (step) begin
      win_idx <= win_idx + 1'b1;
      if (win_end) code <= code + 1'b1;
    end
  end

  // R3
  code_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && win_end && !last_code) |=> (code == $past(code) + 1'b1));
  // R3
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !win_end) |=> $stable(code));
endmodule

// File: rtl/dac_ones_count.sv
module dac_ones_count #(
  parameter int OSR_LOG2 = 6,
  parameter int SETTLE   = 4,
  localparam int CNT_W   = OSR_LOG2 + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_en,
  input  logic                bit_in,
  input  logic [OSR_LOG2-1:0] win_idx,
  input  logic                win_end,
  output logic [CNT_W-1:0]    meas,
  output logic                meas_vld
);
  localparam logic [CNT_W-1:0] SETTLE_V = CNT_W'(SETTLE);
  localparam logic [CNT_W-1:0] MAX_V    = CNT_W'((1 << OSR_LOG2) - SETTLE);

  logic [CNT_W-1:0] cnt_q;
  logic             keep;

  assign keep     = sample_en && ({1'b0, win_idx} >= SETTLE_V) && bit_in;
  assign meas     = cnt_q + CNT_W'(keep);
  assign meas_vld = sample_en && win_end;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (sample_en) cnt_q <= win_end ? '0 : cnt_q + CNT_W'(keep);
  end

  // R4
  meas_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    meas_vld |-> (meas <= MAX_V));
  // R4
  settle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && ({1'b0, win_idx} < SETTLE_V)) |-> (cnt_q == '0));
endmodule

// File: rtl/dac_section_acc.sv
module dac_section_acc
  import dac_bist_pkg::*;
#(
  parameter int SUM_W = 20,
  parameter int CNT_W = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       add_vld,
  input  logic [1:0]                 section,
  input  logic [CNT_W-1:0]           meas,
  output logic [NSEC-1:0][SUM_W-1:0] sums,
  output logic [NSEC-1:0]            add_en
);
  for (genvar g = 0; g < NSEC; g++) begin : g_sec
    assign add_en[g] = add_vld && (section == 2'(g));

    always_ff @(posedge clk) begin
      if (!rst_n || clear) sums[g] <= '0;
      else if (add_en[g])  sums[g] <= sums[g] + SUM_W'(meas);
    end

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> (sums[g] >= $past(sums[g])));
  end

  // R5
  one_section_chk: assert property (@(posedge clk) disable iff (!rst_n)
    add_vld |-> $onehot(add_en));
endmodule

// File: rtl/dac_coef_calc.sv
module dac_coef_calc
  import dac_bist_pkg::*;
#(
  parameter int SUM_W  = 20,
  parameter int COEF_W = 23
) (
  input  logic [NSEC-1:0][SUM_W-1:0] sums,
  output logic signed [COEF_W-1:0]   c_off,
  output logic signed [COEF_W-1:0]   c_lin,
  output logic signed [COEF_W-1:0]   c_sq,
  output logic signed [COEF_W-1:0]   c_cub
);
  function automatic logic signed [COEF_W-1:0] ext(input logic [SUM_W-1:0] v);
    return $signed({{(COEF_W-SUM_W){1'b0}}, v});
  endfunction

  function automatic logic signed [COEF_W-1:0] times3(input logic signed [COEF_W-1:0] v);
    return (v <<< 1) + v;
  endfunction

  logic signed [COEF_W-1:0] s0, s1, s2, s3;
  assign s0 = ext(sums[0]);
  assign s1 = ext(sums[1]);
  assign s2 = ext(sums[2]);
  assign s3 = ext(sums[3]);

  assign c_off = (s0 + s1) + (s2 + s3);
  assign c_lin = (s2 + s3) - (s0 + s1);
  assign c_sq  = (s0 + s3) - (s1 + s2);
  assign c_cub = (s0 - s3) - times3(s1 - s2);
endmodule

// File: rtl/dac_ramp_bist.sv
module dac_ramp_bist
  import dac_bist_pkg::*;
#(
  parameter int CODE_W    = 14,
  parameter int OSR_LOG2  = 6,
  parameter int SETTLE    = 4,
  localparam int CNT_W    = OSR_LOG2 + 1,
  localparam int SUM_W    = CODE_W + OSR_LOG2,
  localparam int COEF_W   = SUM_W + 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     mod_bit,
  output logic                     busy,
  output logic                     done,
  output logic                     mod_en,
  output logic [CODE_W-1:0]        dac_code,
  output logic signed [COEF_W-1:0] coef_offset,
  output logic signed [COEF_W-1:0] coef_linear,
  output logic signed [COEF_W-1:0] coef_square,
  output logic signed [COEF_W-1:0] coef_cube
);
  bist_state_e state_q;
  logic accept, running, win_end, last_code, ramp_end, meas_vld;
  logic [OSR_LOG2-1:0] win_idx;
  logic [CNT_W-1:0] meas;
  logic [NSEC-1:0][SUM_W-1:0] sums;
  logic [NSEC-1:0] add_en;
  logic signed [COEF_W-1:0] c_off, c_lin, c_sq, c_cub;

  assign accept   = start && (state_q == ST_IDLE);
  assign running  = (state_q == ST_RUN);
  assign ramp_end = running && win_end && last_code;
  assign busy     = (state_q != ST_IDLE);
  assign mod_en   = running;

  dac_code_seq #(.CODE_W(CODE_W), .OSR_LOG2(OSR_LOG2)) u_seq (
    .clk(clk), .rst_n(rst_n), .clear(accept), .step(running),
    .code(dac_code), .win_idx(win_idx), .win_end(win_end), .last_code(last_code));

  dac_ones_count #(.OSR_LOG2(OSR_LOG2), .SETTLE(SETTLE)) u_cnt (
    .clk(clk), .rst_n(rst_n), .sample_en(running), .bit_in(mod_bit),
    .win_idx(win_idx), .win_end(win_end), .meas(meas), .meas_vld(meas_vld));

  dac_section_acc #(.SUM_W(SUM_W), .CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear(accept), .add_vld(meas_vld),
    .section(dac_code[CODE_W-1 -: 2]), .meas(meas), .sums(sums), .add_en(add_en));

  dac_coef_calc #(.SUM_W(SUM_W), .COEF_W(COEF_W)) u_coef (
    .sums(sums), .c_off(c_off), .c_lin(c_lin), .c_sq(c_sq), .c_cub(c_cub));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      done        <= 1'b0;
      coef_offset <= '0;
      coef_linear <= '0;
      coef_square <= '0;
      coef_cube   <= '0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) state_q <= ST_RUN;
        ST_RUN:  if (ramp_end) state_q <= ST_FIN;
        ST_FIN: begin
          coef_offset <= c_off;
          coef_linear <= c_lin;
          coef_square <= c_sq;
          coef_cube   <= c_cub;
          done        <= 1'b1;
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && dac_code == '0));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && start && !ramp_end) |=> running);
  // R9
  mod_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mod_en |-> busy);
endmodule

// File: tb/tb_dac_ramp_bist.sv
module tb_dac_ramp_bist;
  localparam int CW = 6;
  localparam int ML = 3;
  localparam int ST = 2;
  localparam int WIN = 1 << ML;
  localparam int NCODE = 1 << CW;
  localparam int CFW = CW + ML + 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mod_bit = 1'b0;
  logic busy, done, mod_en;
  logic [CW-1:0] dac_code;
  logic signed [CFW-1:0] coef_offset, coef_linear, coef_square, coef_cube;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  dac_ramp_bist #(.CODE_W(CW), .OSR_LOG2(ML), .SETTLE(ST)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mod_bit(mod_bit), .busy(busy),
    .done(done), .mod_en(mod_en), .dac_code(dac_code), .coef_offset(coef_offset),
    .coef_linear(coef_linear), .coef_square(coef_square), .coef_cube(coef_cube));

  function automatic logic pat_bit(int pat, int code, int idx);
    case (pat)
      0: return 1'b1;
      1: return idx < ST;
      2: return idx < ((code * 5) % 9);
      default: return ((code * 3 + idx * 5 + code / 4) % 7) < 3;
    endcase
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_run(int pat, bit poke);
    longint s[4];
    longint e_off, e_lin, e_sq, e_cub;
    int code_err = 0, en_err = 0;
    for (int i = 0; i < 4; i++) s[i] = 0;
    @(negedge clk) start = 1'b1;
    for (int k = 0; k < NCODE * WIN; k++) begin
      int c = k / WIN;
      int x = k % WIN;
      @(negedge clk);
      start = poke && (k == NCODE * WIN / 2);
      mod_bit = pat_bit(pat, c, x);
      if (x >= ST && mod_bit) s[c / (NCODE / 4)] += 1;
      if (dac_code != CW'(c) || !busy) code_err++;
      if (!mod_en) en_err++;
    end
    @(negedge clk);
    start = poke;
    check("R2/R3 code ramp mismatches", code_err, 0);
    check("R9 mod_en low during ramp", en_err, 0);
    check("R7 done not early", done, 0);
    @(negedge clk);
    start = 1'b0;
    e_off = s[0] + s[1] + s[2] + s[3];
    e_lin = (s[2] + s[3]) - (s[0] + s[1]);
    e_sq  = (s[0] + s[3]) - (s[1] + s[2]);
    e_cub = (s[0] - s[3]) - 3 * (s[1] - s[2]);
    check("R7 done high", done, 1);
    check("R7 busy low with done", busy, 0);
    check("R4/R5/R6/R10 offset", longint'(coef_offset), e_off);
    check("R5/R6 linear", longint'(coef_linear), e_lin);
    check("R5/R6 square", longint'(coef_square), e_sq);
    check("R6 cube", longint'(coef_cube), e_cub);
    @(negedge clk);
    check("R7 done one clock", done, 0);
    check("R9 mod_en low idle", mod_en, 0);
    check("R8 no restart from ignored start", busy, 0);
    check("R7 coef held", longint'(coef_cube), e_cub);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy in reset", busy, 0);
    check("R1 mod_en in reset", mod_en, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", busy, 0);
    check("R1 done after reset", done, 0);
    check("R1 code after reset", dac_code, 0);
    do_run(0, 1'b0);
    do_run(1, 1'b0);
    do_run(2, 1'b1);
    do_run(3, 1'b0);
    do_run(2, 1'b0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule